// File: doc/BRIEF.md
# PHY Management Register Responder

This block stands in for an Ethernet PHY on the management side of a MAC. A host-side management controller presents one request at a time. Each request is a read or a write and carries a 5-bit PHY address, a 5-bit register number and, for a write, a 16-bit data word. The block answers only at its own PHY address, which is set by a parameter. It holds a file of 32 registers of 16 bits each. Four of the register numbers are not served from storage. They are computed from a link input and from the locally stored advertisement word.

The host side uses a valid/ready handshake. A request is taken on any rising edge where both are high. An accepted read returns its data in the next cycle, together with a single-cycle response pulse. A write stores its data and gives no response. The serial bit framing, real autonegotiation and the physical layer itself are handled elsewhere.

Top module: `phy_mgmt_responder`

## Requirements
- R1: After reset the registers read as follows: register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400 and register 4 (advertisement) reads 0x01E1. The ready output is low while reset is held and high afterwards.
- R2: A read is accepted on a rising edge where valid and ready are both high. The response-valid output is high for exactly the following cycle, and the read data is valid in that cycle. An accepted write produces no response pulse.
- R3: A read of register 1 returns 0x782E while the link input is high and 0x0000 while it is low. The set bits in 0x782E are 14, 13, 12, 11, 5, 3, 2 and 1.
- R4: A read of register 5 returns 0x4001 OR'd with bits 8:5 of register 4. Every other bit is zero.
- R5: A read of register 17 always returns 0x8000.
- R6: While the link input is high, a read of register 18 returns:
  - bit 10 set when register 4 bit 7 or bit 8 is set;
  - bit 11 set when register 4 bit 6 or bit 8 is set;
  - every other bit zero.

  While the link input is low, it returns 0x0000.
- R7: For any register number other than 1, 5, 17 and 18, a read returns the last value written. If that number has not been written since reset, the read returns its reset value (zero unless listed in R1).
- R8: Every accepted write to this PHY clears bit 15 of register 0, after storing its own data. A write to register 0 therefore stores its data with bit 15 forced to zero.
- R9: A read whose PHY address differs from the PHY_ADDR parameter (default 7) returns 0xFFFF. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up_i | input | 1 | Link state used by the computed registers |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_phy_i | input | 5 | Target PHY address |
| req_reg_i | input | 5 | Register number |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | One-cycle pulse with read data |
| rsp_rdata_o | output | 16 | Read data |

## Verification
The only state in the block is the register file and the response stage, so any wrong internal value surfaces on the next read of the affected register. That read returns the wrong word one cycle after it is accepted.

A write that lands on the wrong register, or one that leaks through from a foreign PHY address, stays hidden until that register is read. The bench therefore reads back every register it has just disturbed, and also reads the registers that must not have changed.

The computed registers are read again after each change of the advertisement word and after the link input toggles. A lost or doubled response pulse empties the expected-response queue early or leaves it non-empty at the end, and the bench reports either case.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int NUM_REGS = 2 ** ADDR_W;

    localparam logic [ADDR_W-1:0] IDX_CTRL    = 5'd0;
    localparam logic [ADDR_W-1:0] IDX_STAT    = 5'd1;
    localparam logic [ADDR_W-1:0] IDX_ID_HI   = 5'd2;
    localparam logic [ADDR_W-1:0] IDX_ID_LO   = 5'd3;
    localparam logic [ADDR_W-1:0] IDX_ADV     = 5'd4;
    localparam logic [ADDR_W-1:0] IDX_PARTNER = 5'd5;
    localparam logic [ADDR_W-1:0] IDX_VENDOR  = 5'd17;
    localparam logic [ADDR_W-1:0] IDX_DIAG    = 5'd18;

    localparam logic [DATA_W-1:0] CTRL_SELFCLR_MASK = 16'h7FFF;
    localparam logic [DATA_W-1:0] NO_PHY_WORD      = 16'hFFFF;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] num;
        logic [DATA_W-1:0] wdata;
    } mgmt_req_t;

    function automatic logic [DATA_W-1:0] reset_word(input logic [ADDR_W-1:0] idx);
        case (idx)
            IDX_CTRL:  return 16'h3100;
            IDX_ID_HI: return 16'h0300;
            IDX_ID_LO: return 16'hE400;
            IDX_ADV:   return 16'h01E1;
            default:   return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] stat_word(input logic link);
        return link ? 16'h782E : 16'h0000;
    endfunction

    function automatic logic [DATA_W-1:0] partner_word(input logic [DATA_W-1:0] adv);
        return 16'h4001 | (adv & 16'h01E0);
    endfunction

    function automatic logic [DATA_W-1:0] diag_word(input logic link,
                                                    input logic [DATA_W-1:0] adv);
        logic fast;
        logic full;
        fast = (adv & 16'h0180) != 16'h0000;
        full = (adv & 16'h0140) != 16'h0000;
        if (!link) return 16'h0000;
        return {4'b0, full, fast, 10'b0};
    endfunction

endpackage

// File: rtl/phy_reg_store.sv
module phy_reg_store
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_num,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_num,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] adv_o
);

    logic [DATA_W-1:0] mem [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == 0) begin : g_ctrl
            // Control word: any write clears its top bit after the store.
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[i] <= reset_word(ADDR_W'(i));
                end else if (wr_en) begin
                    if (wr_num == ADDR_W'(i)) mem[i] <= wr_data & CTRL_SELFCLR_MASK;
                    else                      mem[i] <= mem[i] & CTRL_SELFCLR_MASK;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[i] <= reset_word(ADDR_W'(i));
                end else if (wr_en && wr_num == ADDR_W'(i)) begin
                    mem[i] <= wr_data;
                end
            end
        end
    end

    assign rd_data = mem[rd_num];
    assign adv_o   = mem[IDX_ADV];

endmodule

// File: rtl/phy_read_view.sv
module phy_read_view
    import phy_mgmt_pkg::*;
(
    input  logic              hit,
    input  logic              link,
    input  logic [ADDR_W-1:0] num,
    input  logic [DATA_W-1:0] stored,
    input  logic [DATA_W-1:0] adv,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        if (!hit) begin
            rdata = NO_PHY_WORD;
        end else begin
            case (num)
                IDX_STAT:    rdata = stat_word(link);
                IDX_PARTNER: rdata = partner_word(adv);
                IDX_VENDOR:  rdata = 16'h8000;
                IDX_DIAG:    rdata = diag_word(link, adv);
                default:     rdata = stored;
            endcase
        end
    end

endmodule

// File: rtl/phy_mgmt_responder.sv
module phy_mgmt_responder
    import phy_mgmt_pkg::*;
#(
    parameter int PHY_ADDR = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_up_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_phy_i,
    input  logic [ADDR_W-1:0] req_reg_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_rdata_o
);

    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PHY_ADDR);

    mgmt_req_t         req;
    logic              ready_q;
    logic              fire;
    logic              hit;
    logic [DATA_W-1:0] stored;
    logic [DATA_W-1:0] adv;
    logic [DATA_W-1:0] view;

    assign req = '{write: req_write_i, phy: req_phy_i, num: req_reg_i, wdata: req_wdata_i};
    assign fire = req_valid_i && ready_q;
    assign hit  = req.phy == MY_ADDR;

    phy_reg_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (fire && req.write && hit),
        .wr_num  (req.num),
        .wr_data (req.wdata),
        .rd_num  (req.num),
        .rd_data (stored),
        .adv_o   (adv)
    );

    phy_read_view u_view (
        .hit    (hit),
        .link   (link_up_i),
        .num    (req.num),
        .stored (stored),
        .adv    (adv),
        .rdata  (view)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q     <= 1'b0;
            rsp_valid_o <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            ready_q     <= 1'b1;
            rsp_valid_o <= fire && !req.write;
            if (fire && !req.write) rsp_rdata_o <= view;
        end
    end

    assign req_ready_o = ready_q;

endmodule

// File: rtl/phy_mgmt_responder_chk.sv
module phy_mgmt_responder_chk
    import phy_mgmt_pkg::*;
#(
    parameter int PHY_ADDR = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              link_up_i,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic              req_write_i,
    input logic [ADDR_W-1:0] req_phy_i,
    input logic [ADDR_W-1:0] req_reg_i,
    input logic [DATA_W-1:0] req_wdata_i,
    input logic              rsp_valid_o,
    input logic [DATA_W-1:0] rsp_rdata_o
);

    logic rd_fire;
    logic mine;
    assign rd_fire = req_valid_i && req_ready_o && !req_write_i;
    assign mine    = req_phy_i == ADDR_W'(PHY_ADDR);

    AST_READ_GETS_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_fire |=> rsp_valid_o);  // R2

    AST_PULSE_HAS_READ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |-> $past(rd_fire));  // R2

    AST_FOREIGN_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && !mine) |=> rsp_rdata_o == 16'hFFFF);  // R9

    AST_VENDOR_CONST: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && mine && req_reg_i == 5'd17) |=> rsp_rdata_o == 16'h8000);  // R5

    AST_STAT_LINK_DOWN: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && mine && req_reg_i == 5'd1 && !link_up_i) |=> rsp_rdata_o == 16'h0000);  // R3

    AST_PARTNER_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && mine && req_reg_i == 5'd5) |=> (rsp_rdata_o & 16'hFE1F) == 16'h4001);  // R4

    AST_CTRL_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && mine && req_reg_i == 5'd0) |=> !rsp_rdata_o[15]);  // R8

endmodule

bind phy_mgmt_responder phy_mgmt_responder_chk #(.PHY_ADDR(PHY_ADDR)) u_chk (.*);

// File: tb/phy_mgmt_responder_bench.sv
module phy_mgmt_responder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_up_i = 1'b1;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic        req_write_i = 1'b0;
    logic [4:0]  req_phy_i = '0;
    logic [4:0]  req_reg_i = '0;
    logic [15:0] req_wdata_i = '0;
    logic        rsp_valid_o;
    logic [15:0] rsp_rdata_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    phy_mgmt_responder u_phy_mgmt_responder (.*);

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input bit wr, input logic [4:0] phy, input logic [4:0] num,
                        input logic [15:0] data);
        @(negedge clk);
        req_valid_i = 1'b1;
        req_write_i = wr;
        req_phy_i   = phy;
        req_reg_i   = num;
        req_wdata_i = data;
        @(posedge clk);
        while (!req_ready_o) @(posedge clk);
        #1 req_valid_i = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [4:0] num, input logic [15:0] exp,
                      input logic [4:0] phy = 5'd7);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        send(1'b0, phy, num, 16'h0);
    endtask

    task automatic wr(input logic [4:0] num, input logic [15:0] data,
                      input logic [4:0] phy = 5'd7);
        send(1'b1, phy, num, data);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid_o) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected response", rsp_rdata_o, 16'hxxxx);
            end else begin
                check(tag_q.pop_front(), rsp_rdata_o, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ready low in reset", {15'b0, req_ready_o}, 16'h0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 ready after reset", {15'b0, req_ready_o}, 16'h1);

        rd("R1 ctrl reset", 5'd0, 16'h3100);
        rd("R1 id hi", 5'd2, 16'h0300);
        rd("R1 id lo", 5'd3, 16'hE400);
        rd("R1 adv reset", 5'd4, 16'h01E1);
        rd("R7 unwritten zero", 5'd9, 16'h0000);
        rd("R3 stat link up", 5'd1, 16'h782E);
        rd("R4 partner default", 5'd5, 16'h41E1);
        rd("R5 vendor", 5'd17, 16'h8000);
        rd("R6 diag default", 5'd18, 16'h0C00);

        wr(5'd4, 16'h0061);
        rd("R4 partner 10 modes", 5'd5, 16'h4061);
        rd("R6 diag 10 full", 5'd18, 16'h0800);
        wr(5'd4, 16'h0081);
        rd("R6 diag 100 half", 5'd18, 16'h0400);
        rd("R4 partner 100 half", 5'd5, 16'h4081);
        wr(5'd4, 16'h0101);
        rd("R6 diag 100 full", 5'd18, 16'h0C00);

        link_up_i = 1'b0;
        rd("R3 stat link down", 5'd1, 16'h0000);
        rd("R6 diag link down", 5'd18, 16'h0000);
        rd("R4 partner link down", 5'd5, 16'h4101);
        rd("R5 vendor link down", 5'd17, 16'h8000);
        link_up_i = 1'b1;
        rd("R3 stat link back", 5'd1, 16'h782E);

        wr(5'd9, 16'hBEEF);
        wr(5'd31, 16'h1234);
        rd("R7 reg9 store", 5'd9, 16'hBEEF);
        rd("R7 reg31 store", 5'd31, 16'h1234);
        wr(5'd17, 16'h0000);
        rd("R5 vendor after write", 5'd17, 16'h8000);

        wr(5'd0, 16'h8123);
        rd("R8 ctrl self clear", 5'd0, 16'h0123);
        wr(5'd10, 16'h5555);
        rd("R8 ctrl after other write", 5'd0, 16'h0123);

        rd("R9 foreign read", 5'd2, 16'hFFFF, 5'd3);
        rd("R9 foreign vendor read", 5'd17, 16'hFFFF, 5'd8);
        wr(5'd9, 16'h0000, 5'd3);
        rd("R9 foreign write ignored", 5'd9, 16'hBEEF);

        // R2: write gives no pulse
        wr(5'd11, 16'h7777);
        @(negedge clk);
        check("R2 no pulse after write", {15'b0, rsp_valid_o}, 16'h0);
        rd("R2 write then read", 5'd11, 16'h7777);

        repeat (4) @(negedge clk);
        check("R2 all responses seen", 16'(exp_q.size()), 16'h0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule